// File: doc/BRIEF.md
# Module Software Reset Controller

This block holds a bank of software-controlled reset requests, one for each module in the chip. The requests are grouped 32 to a register. Each group has a write-one-to-set register and a separate write-one-to-clear register. Any number of bus agents can assert or release resets on their own modules without reading first, and they cannot undo each other's bits. Several bus ports sit side by side. When two ports touch the same bit in the same cycle, the release takes priority.

Every asserted request drives an internal output state in the bus clock domain. That state is carried into the slow reference clock domain through a two-flop synchroniser to form the module reset pin. The slow clock is sampled in the bus domain to count its rising edges. An asserted output is kept up until a set number of those edges has passed (three by default), which covers at least one complete slow-clock period at the module. Once that minimum has been met, a per-bit hold flag becomes readable. Software can poll this flag instead of waiting a fixed delay. A release written before the minimum has been met is accepted at once in the readback, but the output stays asserted until the minimum has been met.

The bus ports are plain single-cycle ports with no back-pressure. A request is taken in the cycle that `bus_valid` is high. Read data is registered and appears on the cycle after the request.

Top module: `mod_swreset_ctrl`

## Requirements
- R1: A write of a mask to a set register makes every bit written as 1 asserted. Bits written as 0 keep their current value. Writes from different ports in the same cycle to different bits all take effect.
- R2: A write of a mask to a clear register releases every bit written as 1 in the matching set register. Bits written as 0 are untouched. A clear register always reads as zero.
- R3: When one port sets a bit and another port clears the same bit in the same cycle, the bit ends released. Other bits written in that cycle are unaffected.
- R4: The map uses byte addresses. For group g, the set register is at 8g and the clear register is at 8g+4. The hold-status register of group g is at 8*NUM_GROUPS+4g. Reset index i lives in group i/32, bit i%32.
- R5: A read is answered on `bus_rdata` in the cycle after the request. A set register returns the asserted state of all 32 bits of its group.
- R6: After system reset, all requests, output states, reset pins and hold flags are 0.
- R7: Each reset pin `mod_rst_o[i]` follows the output state of bit i through two flops clocked by `ref_clk`. The output state rises one bus cycle after the request is asserted.
- R8: Once an output is asserted, it stays asserted until HOLD_TICKS rising edges of `ref_clk` have been seen. A release written earlier clears the readback at once but not the output. The reset pin is then high on at least two consecutive `ref_clk` rising edges.
- R9: A hold-status bit reads 1 only while its output is asserted and the minimum hold has been met. It reads 0 again once the output is released.
- R10: Writes to hold-status registers, to addresses whose low two bits are not 00, or to addresses beyond the map are ignored. Reads from the last two kinds of address return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low system reset, used in both clock domains |
| ref_clk | input | 1 | Slow reference clock; must be well below half the bus clock |
| bus_valid | input | NUM_PORTS | Per-port request strobe |
| bus_write | input | NUM_PORTS | Per-port write (1) or read (0) |
| bus_addr | input | NUM_PORTS*ADDR_W | Per-port byte address, port p at bits [p*ADDR_W +: ADDR_W] |
| bus_wdata | input | NUM_PORTS*32 | Per-port write data |
| bus_rdata | output | NUM_PORTS*32 | Per-port registered read data |
| mod_rst_o | output | NUM_GROUPS*32 | Module reset pins in the `ref_clk` domain, active high |

## Verification
A wrong request bit shows up on the very next read of its set register, one bus cycle after the write that corrupted it. A bad output state or hold counter takes longer to appear. It shows on `mod_rst_o` two `ref_clk` edges later, or in the hold-status readback once the sampled slow edges have been counted. Because of this delay, the bench measures each pin over whole slow-clock windows rather than single cycles. It counts the consecutive high `ref_clk` samples after an early release, and it checks that a bit lost to a same-cycle clear never pulses its pin at all.

// File: rtl/swr_pkg.sv
package swr_pkg;
  localparam int unsigned GRP_W = 32;

  typedef enum logic [1:0] {
    ACC_NONE = 2'd0,
    ACC_SET  = 2'd1,
    ACC_CLR  = 2'd2,
    ACC_STAT = 2'd3
  } acc_kind_e;
endpackage

// File: rtl/swr_tick_gen.sv
module swr_tick_gen (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_clk,
  output logic tick
);
  logic [2:0] smp_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) smp_q <= '0;
    else        smp_q <= {smp_q[1:0], ref_clk};
  end

  assign tick = smp_q[1] & ~smp_q[2];
endmodule

// File: rtl/swr_bus_port.sv
module swr_bus_port #(
  parameter int unsigned NUM_GROUPS = 2,
  parameter int unsigned ADDR_W     = 8
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 valid,
  input  logic                                 write,
  input  logic [ADDR_W-1:0]                    addr,
  input  logic [swr_pkg::GRP_W-1:0]            wdata,
  input  logic [NUM_GROUPS*swr_pkg::GRP_W-1:0] req_vec,
  input  logic [NUM_GROUPS*swr_pkg::GRP_W-1:0] held_vec,
  output logic [NUM_GROUPS*swr_pkg::GRP_W-1:0] set_mask,
  output logic [NUM_GROUPS*swr_pkg::GRP_W-1:0] clr_mask,
  output logic [swr_pkg::GRP_W-1:0]            rdata
);
  import swr_pkg::*;

  localparam int unsigned WI_W = ADDR_W - 2;

  logic [WI_W-1:0]  word;
  acc_kind_e        kind;
  logic [GRP_W-1:0] rd_next;
  int unsigned      grp;

  assign word = addr[ADDR_W-1:2];

  // Decode: which register kind and which group this address names.
  always_comb begin
    kind = ACC_NONE;
    grp  = 0;
    if (addr[1:0] == 2'b00) begin
      for (int g = 0; g < int'(NUM_GROUPS); g++) begin
        if (word == WI_W'(2*g)) begin
          kind = ACC_SET;
          grp  = g;
        end
        if (word == WI_W'(2*g + 1)) begin
          kind = ACC_CLR;
          grp  = g;
        end
        if (word == WI_W'(2*NUM_GROUPS + g)) begin
          kind = ACC_STAT;
          grp  = g;
        end
      end
    end
  end

  // Write masks, one slice per group.
  always_comb begin
    set_mask = '0;
    clr_mask = '0;
    for (int g = 0; g < int'(NUM_GROUPS); g++) begin
      if (valid && write && grp == g && kind == ACC_SET)
        set_mask[g*GRP_W +: GRP_W] = wdata;
      if (valid && write && grp == g && kind == ACC_CLR)
        clr_mask[g*GRP_W +: GRP_W] = wdata;
    end
  end

  // Read mux; clear registers and unmapped words read zero.
  always_comb begin
    rd_next = '0;
    for (int g = 0; g < int'(NUM_GROUPS); g++) begin
      if (grp == g && kind == ACC_SET)  rd_next = req_vec[g*GRP_W +: GRP_W];
      if (grp == g && kind == ACC_STAT) rd_next = held_vec[g*GRP_W +: GRP_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                rdata <= '0;
    else if (valid && !write)  rdata <= rd_next;
    else                       rdata <= '0;
  end
endmodule

// File: rtl/swr_hold_cell.sv
module swr_hold_cell #(
  parameter int unsigned HOLD_TICKS = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  input  logic tick,
  output logic drv,
  output logic held
);
  localparam int unsigned CW = $clog2(HOLD_TICKS + 1);
  localparam logic [CW-1:0] CNT_MAX = CW'(HOLD_TICKS);

  logic [CW-1:0] cnt_q;
  logic          drv_q;

  assign held = drv_q && (cnt_q == CNT_MAX);
  assign drv  = drv_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      drv_q <= 1'b0;
      cnt_q <= '0;
    end else if (!drv_q) begin
      drv_q <= req;
      cnt_q <= '0;
    end else if (held && !req) begin
      drv_q <= 1'b0;
      cnt_q <= '0;
    end else if (tick && !held) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/swr_ref_sync.sv
module swr_ref_sync #(
  parameter int unsigned W = 64
) (
  input  logic         ref_clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;
  logic [W-1:0] out_q;

  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      out_q  <= '0;
    end else begin
      meta_q <= d;
      out_q  <= meta_q;
    end
  end

  assign q = out_q;
endmodule

// File: rtl/mod_swreset_ctrl.sv
module mod_swreset_ctrl #(
  parameter int unsigned NUM_GROUPS = 2,
  parameter int unsigned NUM_PORTS  = 2,
  parameter int unsigned ADDR_W     = 8,
  parameter int unsigned HOLD_TICKS = 3
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            ref_clk,
  input  logic [NUM_PORTS-1:0]            bus_valid,
  input  logic [NUM_PORTS-1:0]            bus_write,
  input  logic [NUM_PORTS*ADDR_W-1:0]     bus_addr,
  input  logic [NUM_PORTS*32-1:0]         bus_wdata,
  output logic [NUM_PORTS*32-1:0]         bus_rdata,
  output logic [NUM_GROUPS*32-1:0]        mod_rst_o
);
  import swr_pkg::*;

  localparam int unsigned NRST = NUM_GROUPS * GRP_W;

  logic [NRST-1:0] req_q;
  logic [NRST-1:0] drv;
  logic [NRST-1:0] held;
  logic [NRST-1:0] set_all;
  logic [NRST-1:0] clr_all;
  logic [NRST-1:0] port_set [NUM_PORTS];
  logic [NRST-1:0] port_clr [NUM_PORTS];
  logic            tick;

  swr_tick_gen u_tick (
    .clk     (clk),
    .rst_n   (rst_n),
    .ref_clk (ref_clk),
    .tick    (tick)
  );

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    swr_bus_port #(
      .NUM_GROUPS (NUM_GROUPS),
      .ADDR_W     (ADDR_W)
    ) u_port (
      .clk      (clk),
      .rst_n    (rst_n),
      .valid    (bus_valid[p]),
      .write    (bus_write[p]),
      .addr     (bus_addr[p*ADDR_W +: ADDR_W]),
      .wdata    (bus_wdata[p*GRP_W +: GRP_W]),
      .req_vec  (req_q),
      .held_vec (held),
      .set_mask (port_set[p]),
      .clr_mask (port_clr[p]),
      .rdata    (bus_rdata[p*GRP_W +: GRP_W])
    );
  end

  always_comb begin
    set_all = '0;
    clr_all = '0;
    for (int p = 0; p < int'(NUM_PORTS); p++) begin
      set_all = set_all | port_set[p];
      clr_all = clr_all | port_clr[p];
    end
  end

  // Clear dominates set for the same bit in the same cycle.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) req_q <= '0;
    else        req_q <= (req_q | set_all) & ~clr_all;
  end

  for (genvar i = 0; i < NRST; i++) begin : g_bit
    swr_hold_cell #(
      .HOLD_TICKS (HOLD_TICKS)
    ) u_cell (
      .clk   (clk),
      .rst_n (rst_n),
      .req   (req_q[i]),
      .tick  (tick),
      .drv   (drv[i]),
      .held  (held[i])
    );
  end

  swr_ref_sync #(
    .W (NRST)
  ) u_sync (
    .ref_clk (ref_clk),
    .rst_n   (rst_n),
    .d       (drv),
    .q       (mod_rst_o)
  );
endmodule

// File: rtl/swr_ctrl_chk.sv
module swr_ctrl_chk #(
  parameter int unsigned W = 64
) (
  input logic         clk,
  input logic         rst_n,
  input logic [W-1:0] req,
  input logic [W-1:0] set_all,
  input logic [W-1:0] clr_all,
  input logic [W-1:0] drv,
  input logic [W-1:0] held
);
  // R1
  only_set_rises_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((req & ~$past(req)) & ~$past(set_all)) == '0);

  // R2
  only_clr_falls_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((~req & $past(req)) & ~$past(clr_all)) == '0);

  // R3
  clr_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req & $past(set_all & clr_all)) == '0);

  // R7
  drv_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(req) & ~$past(drv)) & ~drv) == '0);

  // R8
  hold_before_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((~drv & $past(drv)) & ~$past(held)) == '0);

  // R9
  held_needs_drv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (held & ~drv) == '0);
endmodule

bind mod_swreset_ctrl swr_ctrl_chk #(.W(NUM_GROUPS*32)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .req     (req_q),
  .set_all (set_all),
  .clr_all (clr_all),
  .drv     (drv),
  .held    (held)
);

// File: tb/mod_swreset_ctrl_tb.sv
`timescale 1ns/1ps
module mod_swreset_ctrl_tb;
  localparam int NG = 2;
  localparam int NP = 2;
  localparam int AW = 8;
  localparam int STAT = 8*NG;

  logic clk = 0, ref_clk = 0, rst_n = 0;
  logic [NP-1:0]    bus_valid = '0, bus_write = '0;
  logic [NP*AW-1:0] bus_addr = '0;
  logic [NP*32-1:0] bus_wdata = '0;
  logic [NP*32-1:0] bus_rdata;
  logic [NG*32-1:0] mod_rst_o;

  int checks = 0, errors = 0;
  logic done = 0;

  always #2 clk = ~clk;
  always #32 ref_clk = ~ref_clk;

  mod_swreset_ctrl #(.NUM_GROUPS(NG), .NUM_PORTS(NP), .ADDR_W(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .ref_clk(ref_clk),
    .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .mod_rst_o(mod_rst_o)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input int p, input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_valid[p] = 1; bus_write[p] = 1;
    bus_addr[p*AW +: AW] = a; bus_wdata[p*32 +: 32] = d;
    @(negedge clk);
    bus_valid[p] = 0; bus_write[p] = 0;
  endtask

  task automatic wr2(input logic [AW-1:0] a0, input logic [31:0] d0,
                     input logic [AW-1:0] a1, input logic [31:0] d1);
    @(negedge clk);
    bus_valid = '1; bus_write = '1;
    bus_addr[0 +: AW] = a0; bus_wdata[0 +: 32] = d0;
    bus_addr[AW +: AW] = a1; bus_wdata[32 +: 32] = d1;
    @(negedge clk);
    bus_valid = '0; bus_write = '0;
  endtask

  task automatic rd(input int p, input logic [AW-1:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_valid[p] = 1; bus_write[p] = 0; bus_addr[p*AW +: AW] = a;
    @(negedge clk);
    bus_valid[p] = 0;
    d = bus_rdata[p*32 +: 32];
  endtask

  task automatic wait_ref(input int n);
    repeat (n) @(negedge ref_clk);
  endtask

  task automatic t_reset;
    logic [31:0] d;
    rd(0, 0, d);       check("R6 set0 after reset", d, 0);
    rd(1, 8, d);       check("R6 set1 after reset", d, 0);
    rd(0, STAT, d);    check("R6 status0 after reset", d, 0);
    check("R6 pins after reset", mod_rst_o, 0);
  endtask

  task automatic t_set_clear;
    logic [31:0] d;
    wr(0, 0, 32'h0000_00A5);
    rd(0, 0, d);  check("R1 set mask", d, 32'h0000_00A5);
    wr(1, 0, 32'h0000_0100);
    rd(1, 0, d);  check("R1 zero bits kept", d, 32'h0000_01A5);
    wr(0, 4, 32'h0000_0005);
    rd(0, 0, d);  check("R2 clear mask", d, 32'h0000_01A0);
    rd(0, 4, d);  check("R2 clear reads zero", d, 0);
    // index 37 -> group 1 bit 5
    wr(0, 8, 32'h1 << (37 % 32));
    rd(0, 8, d);  check("R4 index 37 group1", d, 32'h0000_0020);
    rd(1, 0, d);  check("R4 group0 untouched", d, 32'h0000_01A0);
  endtask

  task automatic t_outputs;
    logic [31:0] d;
    wait_ref(8);
    check("R7 pins follow", mod_rst_o, {32'h0000_0020, 32'h0000_01A0});
    rd(0, STAT, d);     check("R9 status0 held", d, 32'h0000_01A0);
    rd(1, STAT + 4, d); check("R9 status1 held", d, 32'h0000_0020);
    wr(0, 4, 32'hFFFF_FFFF);
    wr(1, 12, 32'hFFFF_FFFF);
    wait_ref(8);
    check("R7 pins released", mod_rst_o, 0);
    rd(0, STAT, d);     check("R9 status0 dropped", d, 0);
  endtask

  task automatic t_min_hold;
    logic [31:0] d;
    int high = 0;
    wr(0, 0, 32'h8);
    wr(0, 4, 32'h8);
    rd(0, 0, d);  check("R8 early clear accepted", d, 0);
    for (int k = 0; k < 20; k++) begin
      @(negedge ref_clk);
      if (mod_rst_o[3]) high++;
      else if (high > 0) break;
    end
    check("R8 pin held two ref edges", 64'(high >= 2), 1);
    wait_ref(4);
    check("R8 pin released", 64'(mod_rst_o[3]), 0);
  endtask

  task automatic t_clear_wins;
    logic [31:0] d;
    logic seen = 0;
    wr(0, 0, 32'h800);
    wr2(0, 32'h200, 4, 32'h200);
    rd(0, 0, d);  check("R3 same bit clear wins", d, 32'h800);
    wr2(0, 32'h400, 4, 32'h800);
    rd(0, 0, d);  check("R3 other bits unaffected", d, 32'h400);
    for (int k = 0; k < 6; k++) begin
      @(negedge ref_clk);
      if (mod_rst_o[9]) seen = 1;
    end
    check("R3 no pulse on lost bit", 64'(seen), 0);
    wr2(0, 32'h2, 8, 32'h4);
    rd(0, 0, d);  check("R1 concurrent port0", d, 32'h402);
    rd(1, 8, d);  check("R1 concurrent port1", d, 32'h4);
  endtask

  task automatic t_unmapped;
    logic [31:0] d;
    wr(0, STAT, 32'hFFFF_FFFF);
    wr(0, 8'h40, 32'hFFFF_FFFF);
    wr(1, 8'h01, 32'hFFFF_FFFF);
    rd(0, 0, d);     check("R10 writes ignored group0", d, 32'h402);
    rd(1, 8, d);     check("R10 writes ignored group1", d, 32'h4);
    rd(0, 8'h40, d); check("R10 unmapped reads zero", d, 0);
    rd(1, 8'h02, d); check("R10 misaligned reads zero", d, 0);
    rd(0, 8'h09, d); check("R5 misaligned set read zero", d, 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    repeat (2) @(negedge clk);
    t_reset();
    t_set_clear();
    t_outputs();
    t_min_hold();
    t_clear_wins();
    t_unmapped();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule